// File: doc/BRIEF.md
# Two-Cycle Standalone DMA Engine

This block is a single-channel DMA engine that sits on a simple synchronous system bus as an ordinary peripheral. While the CPU owns the bus, the engine only answers register accesses: the CPU loads a memory-side pointer, a peripheral-side pointer, a unit count and a control word (enable and transfer direction). The peripheral it serves needs no special hardware. The peripheral only raises a request line, and each unit is moved with ordinary bus cycles that look like cycles the CPU would make.

Each time the peripheral asks for service, the engine raises a bus request. It waits for the grant, then performs one read cycle from the source pointer. It holds the byte read in an internal holding register and performs one write cycle of that byte to the destination pointer. It then releases the bus again. So every unit costs one bus ownership and exactly two bus cycles. After each unit both pointers step up by one and the count steps down. When the count reaches zero, a sticky completion flag raises the interrupt line until the CPU clears it.

Top module: `dual_addr_dma`

## Requirements
- R1: After reset, bus_req_o, m_drive_o, m_rd_o, m_wr_o, dev_ack_o and irq_o are low, and all four registers read as zero.
- R2: The CPU registers are at these offsets: 0 holds the memory pointer, 1 the peripheral pointer, 2 the unit count, 3 the control word. In the control word, bit 0 is enable, bit 1 is direction and bit 2 is done. Values written while the engine is idle read back unchanged, except done. Writing 1 to bit 2 clears done, and writing 0 to it leaves done unchanged.
- R3: A peripheral request is ignored, and bus_req_o stays low, while enable is 0, while done is 1, or while the count is zero.
- R4: bus_req_o rises the cycle after an accepted peripheral request and stays high until the grant is seen. m_drive_o, m_rd_o and m_wr_o never assert unless bus_grant_i is high.
- R5: The cycle after the grant is seen is a read cycle (m_rd_o high). Its address comes from the memory pointer when direction is 0 (memory to peripheral) and from the peripheral pointer when direction is 1.
- R6: The cycle right after the read is a write cycle (m_wr_o high) to the other pointer. It drives the byte that was on m_rdata_i during the read cycle.
- R7: During the write cycle dev_ack_o pulses. After that cycle both pointers have advanced by one, wrapping at the address width, and the count has dropped by one.
- R8: When the count reaches zero, done sets and irq_o stays high until the CPU writes 1 to control bit 2.
- R9: bus_req_o is low in the cycle after every write cycle. Only one unit moves per bus ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_sel_i | input | 1 | CPU selects a register |
| s_wr_i | input | 1 | CPU register write strobe |
| s_addr_i | input | 2 | Register offset |
| s_wdata_i | input | max(AW,CW) | CPU write data |
| s_rdata_o | output | max(AW,CW) | Register read data (combinational) |
| dev_req_i | input | 1 | Peripheral service request |
| dev_ack_o | output | 1 | One unit completed (write cycle) |
| bus_req_o | output | 1 | Request for bus ownership |
| bus_grant_i | input | 1 | Bus ownership granted |
| m_drive_o | output | 1 | Engine drives address and control lines |
| m_rd_o | output | 1 | Read cycle strobe |
| m_wr_o | output | 1 | Write cycle strobe |
| m_addr_o | output | AW | Bus address |
| m_wdata_o | output | DW | Write data (holding register) |
| m_rdata_i | input | DW | Read data returned by bus |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the engine with AW, DW and CW all at 8. With 8-bit pointers, a block that starts at 0xFE runs across the address wrap within a few units. With an 8-bit count, a block of 16 or fewer units finishes in a short run. The bus model adds a random grant delay of zero to three cycles, so the request-hold path and the no-drive-before-grant rule are both exercised, and it checks every moved byte against a snapshot of the address space.

// File: rtl/dual_addr_dma_pkg.sv
package dual_addr_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_READ, ST_WRITE} xfer_st_t;

  localparam logic [1:0] OFS_MEM = 2'd0;
  localparam logic [1:0] OFS_DEV = 2'd1;
  localparam logic [1:0] OFS_CNT = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  localparam int CTL_EN   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_DONE = 2;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dual_addr_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [RW-1:0] cfg_wdata_i,
  input  logic          step_i,
  output logic [RW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [CW-1:0] count_o,
  output logic          en_o,
  output logic          dir_o,
  output logic          done_o
);
  logic [AW-1:0] mem_q, mem_n, dev_q, dev_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          en_q, en_n, dir_q, dir_n, done_q, done_n;
  logic          upd;

  assign upd = cfg_wr_i | step_i;

  always_comb begin
    mem_n  = mem_q;
    dev_n  = dev_q;
    cnt_n  = cnt_q;
    en_n   = en_q;
    dir_n  = dir_q;
    done_n = done_q;
    if (step_i) begin
      mem_n = mem_q + AW'(1);
      dev_n = dev_q + AW'(1);
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) done_n = 1'b1;
    end else if (cfg_wr_i) begin
      case (cfg_addr_i)
        OFS_MEM: mem_n = cfg_wdata_i[AW-1:0];
        OFS_DEV: dev_n = cfg_wdata_i[AW-1:0];
        OFS_CNT: cnt_n = cfg_wdata_i[CW-1:0];
        default: begin
          en_n  = cfg_wdata_i[CTL_EN];
          dir_n = cfg_wdata_i[CTL_DIR];
          if (cfg_wdata_i[CTL_DONE]) done_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      dev_q  <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (upd) begin
      mem_q  <= mem_n;
      dev_q  <= dev_n;
      cnt_q  <= cnt_n;
      en_q   <= en_n;
      dir_q  <= dir_n;
      done_q <= done_n;
    end
  end

  always_comb begin
    case (cfg_addr_i)
      OFS_MEM: rdata_o = RW'(mem_q);
      OFS_DEV: rdata_o = RW'(dev_q);
      OFS_CNT: rdata_o = RW'(cnt_q);
      default: rdata_o = RW'({done_q, dir_q, en_q});
    endcase
  end

  assign mem_addr_o = mem_q;
  assign dev_addr_o = dev_q;
  assign count_o    = cnt_q;
  assign en_o       = en_q;
  assign dir_o      = dir_q;
  assign done_o     = done_q;

  // R7: one unit steps both pointers up and the count down
  p_step_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (count_o == $past(count_o) - CW'(1)) &&
               (mem_addr_o == $past(mem_addr_o) + AW'(1)) &&
               (dev_addr_o == $past(dev_addr_o) + AW'(1)));

  // R8: done stays set until an explicit clear write
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(cfg_wr_i && cfg_addr_i == OFS_CTL && cfg_wdata_i[CTL_DONE])) |=> done_o);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dual_addr_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_req_i,
  input  logic          grant_i,
  input  logic          en_i,
  input  logic          done_i,
  input  logic          count_nz_i,
  input  logic          dir_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic          bus_req_o,
  output logic          drive_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          step_o,
  output logic          idle_o
);
  xfer_st_t      state_q, state_n;
  logic [DW-1:0] buf_q;
  logic          buf_en;
  logic          armed;
  logic [AW-1:0] src_addr, dst_addr;

  assign armed = en_i & ~done_i & count_nz_i;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:  if (armed && dev_req_i) state_n = ST_REQ;
      ST_REQ:   if (grant_i) state_n = ST_READ;
      ST_READ:  state_n = ST_WRITE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign buf_en = (state_q == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= rdata_i;
  end

  assign src_addr  = dir_i ? dev_addr_i : mem_addr_i;
  assign dst_addr  = dir_i ? mem_addr_i : dev_addr_i;

  assign bus_req_o = (state_q != ST_IDLE);
  assign rd_o      = (state_q == ST_READ);
  assign wr_o      = (state_q == ST_WRITE);
  assign drive_o   = rd_o | wr_o;
  assign addr_o    = rd_o ? src_addr : (wr_o ? dst_addr : '0);
  assign wdata_o   = wr_o ? buf_q : '0;
  assign step_o    = wr_o;
  assign idle_o    = (state_q == ST_IDLE);

  // R3: requests are not taken when disarmed
  p_ignore_disarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && (!en_i || done_i || !count_nz_i)) |=> !bus_req_o);

  // R4: request held while waiting for grant
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !grant_i && !drive_o) |=> bus_req_o);

  // R4: bus lines are driven only after a grant was seen
  p_grant_before_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_o) |-> $past(grant_i));

  // R6: read is followed by a write of the captured byte
  p_read_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> (wr_o && wdata_o == $past(rdata_i)));

  // R9: bus released after each unit
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !bus_req_o);
endmodule

// File: rtl/dual_addr_dma.sv
module dual_addr_dma
  import dual_addr_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             s_sel_i,
  input  logic                             s_wr_i,
  input  logic [1:0]                       s_addr_i,
  input  logic [((AW > CW) ? AW : CW)-1:0] s_wdata_i,
  output logic [((AW > CW) ? AW : CW)-1:0] s_rdata_o,
  input  logic                             dev_req_i,
  output logic                             dev_ack_o,
  output logic                             bus_req_o,
  input  logic                             bus_grant_i,
  output logic                             m_drive_o,
  output logic                             m_rd_o,
  output logic                             m_wr_o,
  output logic [AW-1:0]                    m_addr_o,
  output logic [DW-1:0]                    m_wdata_o,
  input  logic [DW-1:0]                    m_rdata_i,
  output logic                             irq_o
);
  localparam int RW = (AW > CW) ? AW : CW;

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          cfg_wr, step, idle;
  logic          en, dir, done;
  logic [AW-1:0] mem_addr, dev_addr;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign cfg_wr = s_sel_i & s_wr_i & idle;

  dma_cfg_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cfg_wr_i   (cfg_wr),
    .cfg_addr_i (s_addr_i),
    .cfg_wdata_i(s_wdata_i),
    .step_i     (step),
    .rdata_o    (s_rdata_o),
    .mem_addr_o (mem_addr),
    .dev_addr_o (dev_addr),
    .count_o    (count),
    .en_o       (en),
    .dir_o      (dir),
    .done_o     (done)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .dev_req_i (dev_req_i),
    .grant_i   (bus_grant_i),
    .en_i      (en),
    .done_i    (done),
    .count_nz_i(|count),
    .dir_i     (dir),
    .mem_addr_i(mem_addr),
    .dev_addr_i(dev_addr),
    .rdata_i   (m_rdata_i),
    .bus_req_o (bus_req_o),
    .drive_o   (m_drive_o),
    .rd_o      (m_rd_o),
    .wr_o      (m_wr_o),
    .addr_o    (m_addr_o),
    .wdata_o   (m_wdata_o),
    .step_o    (step),
    .idle_o    (idle)
  );

  assign dev_ack_o = step;
  assign irq_o     = done;

  // R8: interrupt follows completion of the last unit
  p_irq_on_last_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dev_ack_o && count == CW'(1)) |=> irq_o);
endmodule

// File: tb/dual_addr_dma_tb.sv
module dual_addr_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_sel = 1'b0, s_wr = 1'b0;
  logic [1:0] s_addr = 2'd0;
  logic [7:0] s_wdata = 8'd0;
  logic [7:0] s_rdata;
  logic       dev_req = 1'b0, dev_ack;
  logic       bus_req, grant = 1'b0;
  logic       m_drive, m_rd, m_wr;
  logic [7:0] m_addr, m_wdata, m_rdata;
  logic       irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] space [256];
  logic [7:0] snap  [256];
  logic [7:0] exp_src = 0, exp_dst = 0, seen_rd = 0;
  bit mon_on = 0, dev_on = 0, prev_wr = 0, prev_wait = 0;
  int gcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_addr_dma #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_sel_i(s_sel), .s_wr_i(s_wr), .s_addr_i(s_addr),
    .s_wdata_i(s_wdata), .s_rdata_o(s_rdata), .dev_req_i(dev_req), .dev_ack_o(dev_ack),
    .bus_req_o(bus_req), .bus_grant_i(grant), .m_drive_o(m_drive), .m_rd_o(m_rd),
    .m_wr_o(m_wr), .m_addr_o(m_addr), .m_wdata_o(m_wdata), .m_rdata_i(m_rdata), .irq_o(irq)
  );

  assign m_rdata = m_rd ? space[m_addr] : 8'h00;

  always @(posedge clk) if (m_wr && m_drive) space[m_addr] <= m_wdata;

  always @(posedge clk) begin
    if (!bus_req) begin
      grant <= 1'b0;
      gcnt  <= int'($urandom % 4);
    end else if (gcnt == 0) grant <= 1'b1;
    else gcnt <= gcnt - 1;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit grant_ok(input logic drv, input logic g);
    return !drv || g;
  endfunction

  always @(negedge clk) begin
    if (dev_on) begin
      if (dev_ack) dev_req = 1'b0;
      else if (!dev_req && ($urandom % 3 == 0)) dev_req = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_wr) chk(!bus_req, "R9", "bus_req after write", bus_req, 0);
      if (prev_wait) chk(bus_req, "R4", "request held", bus_req, 1);
      if (m_drive || m_rd || m_wr) chk(grant_ok(1'b1, grant), "R4", "drive without grant", grant, 1);
      if (m_rd) begin
        chk(m_addr == exp_src, "R5", "read address", m_addr, exp_src);
        seen_rd = space[m_addr];
      end
      if (m_wr) begin
        chk(m_addr == exp_dst, "R6", "write address", m_addr, exp_dst);
        chk(m_wdata == seen_rd, "R6", "write data", m_wdata, seen_rd);
        chk(dev_ack, "R7", "ack during write", dev_ack, 1);
        exp_src = exp_src + 8'd1;
        exp_dst = exp_dst + 8'd1;
      end
      prev_wr   = m_wr;
      prev_wait = bus_req && !grant && !m_drive;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    s_sel = 1'b1; s_wr = 1'b1; s_addr = a; s_wdata = d;
    @(negedge clk);
    s_sel = 1'b0; s_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    s_sel = 1'b1; s_wr = 1'b0; s_addr = a;
    #1 d = s_rdata;
    s_sel = 1'b0;
  endtask

  task automatic hold_req_expect_idle(input string rq, input string what);
    dev_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!bus_req && !m_drive, rq, what, bus_req, 0);
    end
    dev_req = 1'b0;
  endtask

  task automatic run_block(input logic [7:0] mar, input logic [7:0] diar,
                           input int n, input bit dir);
    logic [7:0] rd;
    logic [7:0] exp_mem [256];
    int bad, t;
    for (int i = 0; i < 256; i++) snap[i] = space[i];
    cpu_wr(2'd0, mar);
    cpu_wr(2'd1, diar);
    cpu_wr(2'd2, 8'(n));
    cpu_wr(2'd3, {5'd0, 1'b0, dir, 1'b1});
    exp_src = dir ? diar : mar;
    exp_dst = dir ? mar : diar;
    prev_wr = 0; prev_wait = 0;
    mon_on = 1; dev_on = 1;
    t = 0;
    while (!irq && t < 3000) begin @(negedge clk); t++; end
    dev_on = 0;
    dev_req = 1'b0;
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk(irq, "R8", "irq after block", irq, 1);
    for (int i = 0; i < 256; i++) exp_mem[i] = snap[i];
    for (int i = 0; i < n; i++)
      exp_mem[8'((dir ? mar : diar) + i)] = snap[8'((dir ? diar : mar) + i)];
    bad = 0;
    for (int i = 0; i < 256; i++) if (space[i] !== exp_mem[i]) bad++;
    chk(bad == 0, "R6", "moved bytes mismatching", bad, 0);
    cpu_rd(2'd0, rd); chk(rd == 8'(mar + n), "R7", "memory pointer", rd, 8'(mar + n));
    cpu_rd(2'd1, rd); chk(rd == 8'(diar + n), "R7", "peripheral pointer", rd, 8'(diar + n));
    cpu_rd(2'd2, rd); chk(rd == 8'd0, "R7", "count", rd, 0);
    cpu_rd(2'd3, rd); chk(rd == {5'd0, 1'b1, dir, 1'b1}, "R8", "status done", rd, {5'd0, 1'b1, dir, 1'b1});
  endtask

  task automatic clear_done;
    logic [7:0] rd;
    cpu_wr(2'd3, 8'b100);
    @(negedge clk);
    chk(!irq, "R8", "irq after clear", irq, 0);
    cpu_rd(2'd3, rd); chk(rd == 8'd0, "R8", "status after clear", rd, 0);
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) space[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(!bus_req && !m_drive && !m_rd && !m_wr && !dev_ack && !irq, "R1", "idle outputs",
        {bus_req, m_drive, m_rd, m_wr, dev_ack, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      cpu_rd(2'(a), rd);
      chk(rd == 8'd0, "R1", "reset register", rd, 0);
    end

    for (int a = 0; a < 3; a++) begin
      v = 8'($urandom);
      cpu_wr(2'(a), v);
      cpu_rd(2'(a), rd);
      chk(rd == v, "R2", "register readback", rd, v);
    end
    cpu_wr(2'd3, 8'b011);
    cpu_rd(2'd3, rd);
    chk(rd == 8'b011, "R2", "control readback", rd, 8'b011);
    cpu_wr(2'd3, 8'b000);
    cpu_rd(2'd3, rd);
    chk(rd == 8'b000, "R2", "control cleared", rd, 0);

    cpu_wr(2'd2, 8'd5);
    hold_req_expect_idle("R3", "request while disabled");
    cpu_wr(2'd2, 8'd0);
    cpu_wr(2'd3, 8'b001);
    hold_req_expect_idle("R3", "request with zero count");

    run_block(8'hFE, 8'h40, 4, 1'b0);
    hold_req_expect_idle("R3", "request while done");
    cpu_wr(2'd3, 8'b001);
    cpu_rd(2'd3, rd);
    chk(rd == 8'b101, "R2", "done kept when bit2 is 0", rd, 8'b101);
    clear_done();

    run_block(8'h10, 8'h90, 1, 1'b1);
    clear_done();

    for (int k = 0; k < 8; k++) begin
      bit d;
      int n;
      d = 1'($urandom);
      n = 1 + int'($urandom % 16);
      run_block(8'($urandom % 8'h70), 8'(8'h80 + ($urandom % 8'h70)), n, d);
      clear_done();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule